// File: doc/BRIEF.md
# Interrupt Controller Programming Front End

This block is the register-side front end of one chip of a classic eight-line programmable interrupt controller. It sits on a byte-wide write bus with a one-bit address: address 0 selects the command/status port and address 1 selects the data/mask port. A command write with bit 4 set always starts initialization. The following data writes are then steered, in order, into the vector base, the cascade byte and the mode byte. Bits 1 and 0 of the first initialization byte decide which of these writes are expected.

Once initialized, command writes are decoded as operation words. One group performs end-of-interrupt clears on the in-service vector. The other group chooses whether the command port reads back pending requests or in-service bits. The data port loads and returns the mask. The request vector comes in from the neighbouring priority logic. The in-service vector is held here: the priority logic sets bits through an acknowledge vector, and this block clears them. The stored configuration bytes are driven out for the rest of the controller.

Top module: `pic_cmd_front`

## Requirements
- R1: After reset the sequencer expects the first initialization byte (`init_done`=0), mask, in-service vector and all stored configuration bytes are zero, and the readback selector is 0x02, so a command-port read returns `irr_in`.
- R2: A command-port write with bit 4 = 1 in any state stores the byte on `init_cfg` and makes the next data write the vector base, restarting any sequence in progress.
- R3: The data write after the first initialization byte stores `vec_base`. The sequence then expects the cascade byte if bit 1 of `init_cfg` is 0. Otherwise it expects the mode byte if bit 0 is 1. Otherwise it is done (`init_done`=1).
- R4: A data write while the cascade byte is expected stores `cascade_cfg`, then expects the mode byte if `init_cfg` bit 0 is 1 and finishes otherwise. A data write while the mode byte is expected stores `mode_cfg` and finishes.
- R5: A data write loads the mask (`imr_out`) only before any initialization byte or after initialization is done. Data writes inside an initialization sequence leave the mask unchanged.
- R6: When initialization is done, a command write with bits 4:3 = 00 is an end-of-interrupt word and one with bits 4:3 = 01 is a readback select word. A command write with bit 4 = 0 while a sequence is in progress has no effect.
- R7: An end-of-interrupt word with bit 5 (EOI) = 1, bit 7 (R) = 0 and bit 6 (SL) = 1 clears the in-service bit numbered by bits 2:0.
- R8: An end-of-interrupt word with EOI = 1, R = 0 and SL = 0 clears only the lowest-numbered set in-service bit, and does nothing if none is set.
- R9: An end-of-interrupt word with EOI = 0, or with R = 1, leaves the in-service vector unchanged.
- R10: A command-port read returns `irr_in` when bits 1:0 of the last readback select word are 10, `isr_out` when they are 11, and zero otherwise. A data-port read always returns the mask.
- R11: When an end-of-interrupt clear and an acknowledge set reach the in-service vector in the same cycle, the clear is applied first and then the set, so an acknowledged bit ends up 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one byte per cycle |
| bus_addr | input | 1 | 0 = command/status port, 1 = data/mask port |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the port selected by `bus_addr` (combinational) |
| irr_in | input | 8 | Pending request vector from the priority logic |
| isr_set | input | 8 | Acknowledge: in-service bits to set this cycle |
| isr_out | output | 8 | In-service vector |
| imr_out | output | 8 | Mask register |
| vec_base | output | 8 | Stored vector base byte |
| cascade_cfg | output | 8 | Stored cascade byte |
| mode_cfg | output | 8 | Stored mode byte |
| init_cfg | output | 8 | Stored first initialization byte |
| init_done | output | 1 | Initialization finished, operation words accepted |

## Verification
The initialization sequencer is swept over all four settings of the two first-byte steering bits. Each sweep checks the completion flag after every data write, which separates the one-, two- and three-write paths, and a restart in the middle of a sequence shows that ICW1 takes priority over the steps in progress. Specific end-of-interrupt is swept over every level. The non-specific clear is swept over all 256 in-service patterns against v & (v-1), which exposes any error in the lowest-bit search, including the empty case. Words that must have no effect are compared against an unchanged vector, and the same-cycle clear-and-set cases show the order in which the two are applied.

// File: rtl/pic_front_pkg.sv
package pic_front_pkg;

   typedef enum logic [2:0] {
      SEQ_WAIT_ICW1 = 3'd0,
      SEQ_WAIT_ICW2 = 3'd1,
      SEQ_WAIT_ICW3 = 3'd2,
      SEQ_WAIT_ICW4 = 3'd3,
      SEQ_READY     = 3'd4
   } seq_state_e;

   // initialization byte fields
   localparam int INIT_BIT = 4;
   localparam int SNGL_BIT = 1;
   localparam int IC4_BIT  = 0;
   // operation word group select
   localparam int GRP_LO   = 3;
   // end-of-interrupt word fields
   localparam int R_BIT    = 7;
   localparam int SL_BIT   = 6;
   localparam int EOI_BIT  = 5;
   // readback selector encodings
   localparam logic [1:0] RSEL_IRR = 2'b10;
   localparam logic [1:0] RSEL_ISR = 2'b11;
   localparam logic [7:0] RSEL_RESET = 8'h02;

endpackage

// File: rtl/pic_lowest_bit.sv
module pic_lowest_bit #(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] vec,
   output logic [WIDTH-1:0] lowest
);
   logic [WIDTH:0] seen;

   assign seen[0] = 1'b0;

   genvar gi;
   generate
      for (gi = 0; gi < WIDTH; gi++) begin : g_scan
         assign lowest[gi]  = vec[gi] & ~seen[gi];
         assign seen[gi+1]  = seen[gi] | vec[gi];
      end
   endgenerate
endmodule

// File: rtl/pic_icw_seq.sv
module pic_icw_seq
   import pic_front_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_wr,
   input  logic              dat_wr,
   input  logic [DATA_W-1:0] wdata,
   output seq_state_e        state,
   output logic [DATA_W-1:0] init_q,
   output logic [DATA_W-1:0] base_q,
   output logic [DATA_W-1:0] casc_q,
   output logic [DATA_W-1:0] mode_q,
   output logic              mask_ld,
   output logic              ocw_wr
);
   seq_state_e state_d;
   logic       is_init;

   assign is_init = cmd_wr & wdata[INIT_BIT];

   always_comb begin
      state_d = state;
      if (is_init) begin
         state_d = SEQ_WAIT_ICW2;
      end else if (dat_wr) begin
         case (state)
            SEQ_WAIT_ICW2: begin
               if (!init_q[SNGL_BIT])     state_d = SEQ_WAIT_ICW3;
               else if (init_q[IC4_BIT])  state_d = SEQ_WAIT_ICW4;
               else                       state_d = SEQ_READY;
            end
            SEQ_WAIT_ICW3: state_d = init_q[IC4_BIT] ? SEQ_WAIT_ICW4 : SEQ_READY;
            SEQ_WAIT_ICW4: state_d = SEQ_READY;
            default:       state_d = state;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= SEQ_WAIT_ICW1;
         init_q <= '0;
         base_q <= '0;
         casc_q <= '0;
         mode_q <= '0;
      end else begin
         state <= state_d;
         if (is_init) init_q <= wdata;
         if (dat_wr && state == SEQ_WAIT_ICW2) base_q <= wdata;
         if (dat_wr && state == SEQ_WAIT_ICW3) casc_q <= wdata;
         if (dat_wr && state == SEQ_WAIT_ICW4) mode_q <= wdata;
      end
   end

   assign mask_ld = dat_wr & ((state == SEQ_WAIT_ICW1) | (state == SEQ_READY));
   assign ocw_wr  = cmd_wr & ~wdata[INIT_BIT] & (state == SEQ_READY);

   // R2
   icw1_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && wdata[INIT_BIT]) |=> (state == SEQ_WAIT_ICW2 && init_q == $past(wdata)));

   // R4
   icw4_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dat_wr && !cmd_wr && state == SEQ_WAIT_ICW4) |=> (state == SEQ_READY));

   // R6
   seq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!dat_wr && !(cmd_wr && wdata[INIT_BIT])) |=> $stable(state));
endmodule

// File: rtl/pic_isr_ctl.sv
module pic_isr_ctl
   import pic_front_pkg::*;
#(
   parameter int LINES  = 8,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ocw2_wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [LINES-1:0]  isr_set,
   output logic [LINES-1:0]  isr_q,
   output logic [DATA_W-1:0] ocw2_q
);
   localparam int LVL_W = (LINES > 1) ? $clog2(LINES) : 1;

   logic [LINES-1:0] low_hit;
   logic [LINES-1:0] clr;
   logic [LVL_W-1:0] level;
   logic             do_eoi;

   pic_lowest_bit #(.WIDTH(LINES)) u_low (
      .vec    (isr_q),
      .lowest (low_hit)
   );

   assign level  = wdata[LVL_W-1:0];
   assign do_eoi = ocw2_wr & wdata[EOI_BIT] & ~wdata[R_BIT];

   always_comb begin
      clr = '0;
      if (do_eoi) begin
         if (wdata[SL_BIT]) clr = LINES'(1) << level;
         else               clr = low_hit;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         isr_q  <= '0;
         ocw2_q <= '0;
      end else begin
         isr_q <= (isr_q & ~clr) | isr_set;
         if (ocw2_wr) ocw2_q <= wdata;
      end
   end

   // R7
   spec_eoi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ocw2_wr && wdata[EOI_BIT] && !wdata[R_BIT] && wdata[SL_BIT] && isr_set == '0)
      |=> !isr_q[ocw2_q[LVL_W-1:0]]);

   // R8
   nonspec_eoi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ocw2_wr && wdata[EOI_BIT] && !wdata[R_BIT] && !wdata[SL_BIT] && isr_set == '0)
      |=> (isr_q == ($past(isr_q) & ($past(isr_q) - LINES'(1)))));

   // R9
   no_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ocw2_wr && (!wdata[EOI_BIT] || wdata[R_BIT]) && isr_set == '0) |=> $stable(isr_q));

   // R11
   set_after_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (isr_set != '0) |=> ((isr_q & $past(isr_set)) == $past(isr_set)));
endmodule

// File: rtl/pic_read_sel.sv
module pic_read_sel
   import pic_front_pkg::*;
#(
   parameter int LINES  = 8,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ocw3_wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              data_port,
   input  logic [LINES-1:0]  irr,
   input  logic [LINES-1:0]  isr,
   input  logic [LINES-1:0]  imr,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] ocw3_q;

   always_ff @(posedge clk) begin
      if (!rst_n)       ocw3_q <= DATA_W'(RSEL_RESET);
      else if (ocw3_wr) ocw3_q <= wdata;
   end

   always_comb begin
      if (data_port)                   rdata = DATA_W'(imr);
      else if (ocw3_q[1:0] == RSEL_IRR) rdata = DATA_W'(irr);
      else if (ocw3_q[1:0] == RSEL_ISR) rdata = DATA_W'(isr);
      else                             rdata = '0;
   end

   // R10
   rsel_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ocw3_wr |=> (ocw3_q == $past(wdata)));
endmodule

// File: rtl/pic_cmd_front.sv
module pic_cmd_front
   import pic_front_pkg::*;
#(
   parameter int LINES  = 8,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [LINES-1:0]  irr_in,
   input  logic [LINES-1:0]  isr_set,
   output logic [LINES-1:0]  isr_out,
   output logic [LINES-1:0]  imr_out,
   output logic [DATA_W-1:0] vec_base,
   output logic [DATA_W-1:0] cascade_cfg,
   output logic [DATA_W-1:0] mode_cfg,
   output logic [DATA_W-1:0] init_cfg,
   output logic              init_done
);
   generate
      if (DATA_W < 8) begin : g_bad_width
         $error("DATA_W must hold the 8-bit command fields");
      end
      if (LINES < 2 || LINES > 8 || (LINES & (LINES - 1)) != 0) begin : g_bad_lines
         $error("LINES must be a power of two from 2 to 8");
      end
   endgenerate

   seq_state_e        state;
   logic              cmd_wr, dat_wr;
   logic              mask_ld, ocw_wr;
   logic              ocw2_wr, ocw3_wr;
   logic [DATA_W-1:0] ocw2_q;
   logic [LINES-1:0]  imr_q;

   assign cmd_wr = bus_wr & ~bus_addr;
   assign dat_wr = bus_wr &  bus_addr;

   pic_icw_seq #(.DATA_W(DATA_W)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .cmd_wr  (cmd_wr),
      .dat_wr  (dat_wr),
      .wdata   (bus_wdata),
      .state   (state),
      .init_q  (init_cfg),
      .base_q  (vec_base),
      .casc_q  (cascade_cfg),
      .mode_q  (mode_cfg),
      .mask_ld (mask_ld),
      .ocw_wr  (ocw_wr)
   );

   assign ocw2_wr = ocw_wr & ~bus_wdata[GRP_LO];
   assign ocw3_wr = ocw_wr &  bus_wdata[GRP_LO];

   pic_isr_ctl #(.LINES(LINES), .DATA_W(DATA_W)) u_isr (
      .clk     (clk),
      .rst_n   (rst_n),
      .ocw2_wr (ocw2_wr),
      .wdata   (bus_wdata),
      .isr_set (isr_set),
      .isr_q   (isr_out),
      .ocw2_q  (ocw2_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)       imr_q <= '0;
      else if (mask_ld) imr_q <= bus_wdata[LINES-1:0];
   end

   assign imr_out   = imr_q;
   assign init_done = (state == SEQ_READY);

   pic_read_sel #(.LINES(LINES), .DATA_W(DATA_W)) u_rd (
      .clk       (clk),
      .rst_n     (rst_n),
      .ocw3_wr   (ocw3_wr),
      .wdata     (bus_wdata),
      .data_port (bus_addr),
      .irr       (irr_in),
      .isr       (isr_out),
      .imr       (imr_q),
      .rdata     (bus_rdata)
   );

   // R5
   mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dat_wr && !init_done && state != SEQ_WAIT_ICW1) |=> $stable(imr_out));

   // R6
   ocw_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && !bus_wdata[INIT_BIT] && !init_done && isr_set == '0) |=> $stable(isr_out));

   // R9
   ocw2_record_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ocw2_wr |=> (ocw2_q == $past(bus_wdata)));
endmodule

// File: tb/tb_pic_cmd_front.sv
module tb_pic_cmd_front;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_wr = 1'b0;
   logic       bus_addr = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic [7:0] irr_in = '0;
   logic [7:0] isr_set = '0;
   logic [7:0] isr_out, imr_out, vec_base, cascade_cfg, mode_cfg, init_cfg;
   logic       init_done;

   int checks = 0;
   int failures = 0;

   always #5 clk = ~clk;

   pic_cmd_front dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irr_in(irr_in),
      .isr_set(isr_set), .isr_out(isr_out), .imr_out(imr_out),
      .vec_base(vec_base), .cascade_cfg(cascade_cfg), .mode_cfg(mode_cfg),
      .init_cfg(init_cfg), .init_done(init_done)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic a, input logic [7:0] d, input logic [7:0] s = 8'h00);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d; isr_set = s;
      @(negedge clk);
      bus_wr = 1'b0; isr_set = 8'h00;
   endtask

   task automatic rd(input logic a, output logic [7:0] v);
      @(negedge clk);
      bus_addr = a;
      #1 v = bus_rdata;
   endtask

   task automatic ack(input logic [7:0] s);
      @(negedge clk);
      isr_set = s;
      @(negedge clk);
      isr_set = 8'h00;
   endtask

   task automatic clear_all();
      for (int j = 0; j < 8; j++) wr(1'b0, 8'h60 | 8'(j));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [7:0] v;
      irr_in = 8'hA5;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(1'b0, v); chk("R1 default readback is request vector", v, 8'hA5);
      rd(1'b1, v); chk("R1 mask zero", v, 8'h00);
      chk("R1 isr zero", isr_out, 0);
      chk("R1 not initialized", init_done, 0);
      chk("R1 config zero", {vec_base, cascade_cfg, mode_cfg, init_cfg}, 0);

      // R5 mask load before any initialization byte
      wr(1'b1, 8'h3C);
      chk("R5 mask load before init", imr_out, 8'h3C);

      // R2 R3 R4 sweep of steering bits
      for (int k = 0; k < 4; k++) begin
         logic [7:0] b1;
         logic       sngl, ic4, rdy;
         b1 = 8'h10 | 8'(k);
         sngl = b1[1]; ic4 = b1[0];
         wr(1'b0, b1);
         chk("R2 init byte stored", init_cfg, b1);
         chk("R2 busy after init byte", init_done, 0);
         wr(1'b1, 8'h20 + 8'(k * 8));
         chk("R3 vector base stored", vec_base, 8'h20 + k * 8);
         rdy = sngl && !ic4;
         chk("R3 done after base", init_done, rdy);
         chk("R5 mask untouched by base", imr_out, 8'h3C);
         if (!sngl) begin
            wr(1'b1, 8'h04 + 8'(k));
            chk("R4 cascade stored", cascade_cfg, 8'h04 + k);
            chk("R4 done after cascade", init_done, !ic4);
         end
         if (ic4) begin
            wr(1'b1, 8'h01 + 8'(k * 2));
            chk("R4 mode stored", mode_cfg, 8'h01 + k * 2);
            chk("R4 done after mode", init_done, 1);
         end
         chk("R5 mask untouched in sequence", imr_out, 8'h3C);
      end

      // R2 restart mid-sequence; R6 command word ignored during sequence
      wr(1'b0, 8'h11);
      wr(1'b1, 8'h40);
      wr(1'b0, 8'h0B);
      wr(1'b0, 8'h13);
      chk("R2 restart clears done", init_done, 0);
      wr(1'b1, 8'h48);
      chk("R3 base after restart", vec_base, 8'h48);
      chk("R3 expects mode byte", init_done, 0);
      wr(1'b1, 8'h02);
      chk("R4 mode after restart", mode_cfg, 8'h02);
      chk("R4 done", init_done, 1);
      ack(8'h5A);
      rd(1'b0, v); chk("R6 ignored select word left request readback", v, 8'hA5);

      // R5 mask in ready state
      wr(1'b1, 8'hC3);
      rd(1'b1, v); chk("R5 mask load when ready", v, 8'hC3);

      // R10 readback select
      wr(1'b0, 8'h0B);
      rd(1'b0, v); chk("R10 isr readback", v, 8'h5A);
      irr_in = 8'h3E;
      wr(1'b0, 8'h0A);
      rd(1'b0, v); chk("R10 irr readback", v, 8'h3E);
      wr(1'b0, 8'h08);
      rd(1'b0, v); chk("R10 other select reads zero", v, 8'h00);
      rd(1'b1, v); chk("R10 data port mask", v, 8'hC3);
      wr(1'b0, 8'h0B);

      // R7 specific EOI sweep
      clear_all();
      chk("R7 clear all", isr_out, 0);
      for (int l = 0; l < 8; l++) begin
         ack(8'hFF);
         wr(1'b0, 8'h60 | 8'(l));
         chk("R7 specific clear", isr_out, 8'hFF & ~(8'h01 << l));
         rd(1'b0, v); chk("R7 readback", v, 8'hFF & ~(8'h01 << l));
         clear_all();
      end

      // R8 non-specific EOI over all patterns
      for (int p = 0; p < 256; p++) begin
         logic [7:0] pv;
         pv = 8'(p);
         clear_all();
         ack(pv);
         wr(1'b0, 8'h20);
         chk("R8 lowest bit cleared", isr_out, pv & (pv - 8'd1));
      end

      // R9 words that change nothing
      clear_all();
      ack(8'h96);
      wr(1'b0, 8'hC3); chk("R9 set-priority", isr_out, 8'h96);
      wr(1'b0, 8'h40); chk("R9 no-op", isr_out, 8'h96);
      wr(1'b0, 8'hA0); chk("R9 rotate nonspecific", isr_out, 8'h96);
      wr(1'b0, 8'hE1); chk("R9 rotate specific", isr_out, 8'h96);

      // R11 clear then set in the same cycle
      clear_all();
      ack(8'h08);
      wr(1'b0, 8'h63, 8'h08);
      chk("R11 specific clear with same-bit set", isr_out, 8'h08);
      clear_all();
      ack(8'h06);
      wr(1'b0, 8'h20, 8'h01);
      chk("R11 nonspecific clear with other set", isr_out, 8'h05);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule